// File: doc/BRIEF.md
# Exception Condition and Vector Logic

This block sits next to a simple in-order pipeline and picks, each cycle, the one exception that the pipeline must take. It looks at the decode flags of the completing instruction, the translation-miss flags, the floating-point summary flag, the critical interrupt pin and the top bit of the decrementer. Each condition is gated by its own machine-state enable: two floating-point mode bits ORed together, the user-mode bit, the floating-point-available bit, the external and critical enables, and the single-step and branch-step trace bits.

When several conditions hold in the same cycle, a fixed priority picks one winner. The block then reports it as a valid strobe and a 20-bit vector offset. For program exceptions it also gives a one-hot subtype code. The selection is combinational from the current inputs.

The only state is the decrementer edge detector and a pending flag. That flag keeps a decrementer event that arrived while the external enable was off, so that it is taken once the enable comes back.

Top module: `excVectorUnit`

## Requirements
- R1: With no enabled condition, `excValid` is 0, `excVector` is 0 and `progCause` is 0. Each taken exception drives `excValid` high with its offset: program 0x00700, FP unavailable 0x00800, decrementer 0x00900, critical 0x00A00, system call 0x00C00, trace 0x00D00, instruction miss 0x01000, data load miss 0x01100, data store miss 0x01200.
- R2: While `excValid` is 1, `excVector` never lies in 0x00B00–0x00BFF or 0x00E00–0x00FFF.
- R3: A floating-point enabled program exception is raised when `fpSummary` is 1 and at least one of `msrFe0` and `msrFe1` is 1. It sets `progCause` bit 0.
- R4: A privileged program exception (`progCause` bit 2) is raised when `msrPr` is 1 and either `isPriv` is 1, or `isSprMove` is 1 with `sprKnown` at 0 and `sprFieldMsb` at 1. With `msrPr` at 0 neither case raises one.
- R5: An illegal opcode sets `progCause` bit 1 and a met trap condition sets bit 3. When several subtypes hold at once, exactly one bit is set, in the order illegal, privileged, trap, FP enabled. `progCause` is 0 unless the vector is 0x00700.
- R6: A floating-point instruction (`isFpOp`, covering loads, stores and moves) raises FP unavailable only while `msrFp` is 0.
- R7: The decrementer exception is recognised only on a 0-to-1 change of `decTop` while `msrEe` is 1. A `decTop` held at 1 does not fire again. A `decTop` already at 1 when reset is released does not count as a rise.
- R8: A decrementer rise that is not taken stays pending. This covers a rise while `msrEe` is 0 and a rise masked by a higher-priority exception. A pending event is taken in the first cycle in which `msrEe` is 1 and nothing higher wins, and the pending state clears when it is taken.
- R9: A critical interrupt is taken when `critIn` is 1 and `msrCe` is 1, and never when `msrCe` is 0.
- R10: Trace is taken for a completing instruction when `msrSe` is 1, or when `isBranch` and `msrBe` are both 1.
- R11: `isSysCall` raises system call, `itlbMiss` raises instruction miss, `dtlbLoadMiss` raises data load miss, and either `dtlbStoreMiss` or `storeChangeNeeded` raises data store miss.
- R12: The priority, highest first, is: instruction miss, program, FP unavailable, system call, data load miss, data store miss, trace, critical, decrementer.
- R13: With `instValid` at 0 all instruction conditions (program, FP unavailable, system call, data misses, trace) are ignored. Instruction miss, critical interrupt and decrementer still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | An instruction completes this cycle |
| isIllegal | input | 1 | Illegal opcode or opcode combination |
| isPriv | input | 1 | Privileged opcode |
| trapHit | input | 1 | A trap instruction's condition is met |
| isFpOp | input | 1 | Any floating-point instruction |
| isSysCall | input | 1 | System call instruction |
| isBranch | input | 1 | Completing instruction is a branch |
| isSprMove | input | 1 | Move to or from a special register |
| sprKnown | input | 1 | The move's SPR field names an implemented register |
| sprFieldMsb | input | 1 | Most significant bit of the move's SPR field |
| fpSummary | input | 1 | Floating-point enabled-exception summary flag |
| decTop | input | 1 | Top bit of the decrementer |
| critIn | input | 1 | Critical interrupt request pin |
| itlbMiss | input | 1 | Instruction fetch translation miss |
| dtlbLoadMiss | input | 1 | Data load translation miss |
| dtlbStoreMiss | input | 1 | Data store translation miss |
| storeChangeNeeded | input | 1 | Store hit a page whose change bit must still be set |
| msrFe0 | input | 1 | Floating-point exception mode bit 0 |
| msrFe1 | input | 1 | Floating-point exception mode bit 1 |
| msrPr | input | 1 | User-mode bit |
| msrFp | input | 1 | Floating point available |
| msrEe | input | 1 | External and decrementer enable |
| msrCe | input | 1 | Critical interrupt enable |
| msrSe | input | 1 | Single-step trace enable |
| msrBe | input | 1 | Branch trace enable |
| excValid | output | 1 | An exception is taken this cycle |
| excVector | output | 20 | Vector offset of the taken exception |
| progCause | output | 4 | One-hot program subtype: bit0 FP enabled, bit1 illegal, bit2 privileged, bit3 trap |

## Verification
Each cause is first driven alone, once with its enable set and once with it cleared. This separates a missing gate from a wrong vector. Pairs of adjacent-priority causes are then driven together, which exposes any swap in the priority chain, and program subtypes are combined to pin down the cause order. The decrementer is tried with a fresh rise, a held level, a rise under a cleared enable, a rise masked by a critical interrupt, and a level already high at reset release. These patterns tell an edge detector apart from a level test, and a kept pending event apart from a lost or repeated one.

// File: rtl/excPkg.sv
package excPkg;
  localparam int VEC_W   = 20;
  localparam int NUM_SRC = 9;
  localparam int CAUSE_W = 4;

  // Priority index, 0 is highest
  localparam int SRC_ITLB = 0;
  localparam int SRC_PROG = 1;
  localparam int SRC_FPU  = 2;
  localparam int SRC_SC   = 3;
  localparam int SRC_DLD  = 4;
  localparam int SRC_DST  = 5;
  localparam int SRC_TRC  = 6;
  localparam int SRC_CRIT = 7;
  localparam int SRC_DEC  = 8;

  // Program subtype bit positions in the cause field
  localparam int CAUSE_FPEN = 0;
  localparam int CAUSE_ILL  = 1;
  localparam int CAUSE_PRIV = 2;
  localparam int CAUSE_TRAP = 3;

  typedef struct packed {
    logic decReq;   // decrementer rise this cycle or one still waiting
  } ctrlStrobes_t;

  function automatic logic [VEC_W-1:0] vecOf(input int idx);
    case (idx)
      SRC_ITLB: vecOf = 20'h01000;
      SRC_PROG: vecOf = 20'h00700;
      SRC_FPU:  vecOf = 20'h00800;
      SRC_SC:   vecOf = 20'h00C00;
      SRC_DLD:  vecOf = 20'h01100;
      SRC_DST:  vecOf = 20'h01200;
      SRC_TRC:  vecOf = 20'h00D00;
      SRC_CRIT: vecOf = 20'h00A00;
      SRC_DEC:  vecOf = 20'h00900;
      default:  vecOf = '0;
    endcase
  endfunction
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         decTop,
  input  logic         decTaken,
  input  logic         msrEe,
  output ctrlStrobes_t strobes
);
  logic decTopQ;
  logic decPend;
  logic decRise;

  assign decRise        = decTop & ~decTopQ;
  assign strobes.decReq = decRise | decPend;

  // decTopQ resets high so a level already set at release is not a rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decTopQ <= 1'b1;
      decPend <= 1'b0;
    end else begin
      decTopQ <= decTop;
      decPend <= strobes.decReq & ~decTaken;
    end
  end

  AST_DEC_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    decTaken |=> !decPend); // R8

  AST_DEC_KEEP_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (decRise && !msrEe) |=> decPend); // R8

  AST_DEC_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    decTaken |-> (decPend || (decTop && !decTopQ))); // R7
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               instValid,
  input  logic               isIllegal,
  input  logic               isPriv,
  input  logic               trapHit,
  input  logic               isFpOp,
  input  logic               isSysCall,
  input  logic               isBranch,
  input  logic               isSprMove,
  input  logic               sprKnown,
  input  logic               sprFieldMsb,
  input  logic               fpSummary,
  input  logic               critIn,
  input  logic               itlbMiss,
  input  logic               dtlbLoadMiss,
  input  logic               dtlbStoreMiss,
  input  logic               storeChangeNeeded,
  input  logic               msrFe0,
  input  logic               msrFe1,
  input  logic               msrPr,
  input  logic               msrFp,
  input  logic               msrEe,
  input  logic               msrCe,
  input  logic               msrSe,
  input  logic               msrBe,
  output logic [NUM_SRC-1:0] grant,
  output logic               excValid,
  output logic [VEC_W-1:0]   excVector,
  output logic [CAUSE_W-1:0] progCause
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC:0]   seenAbove;
  logic               progFpEn, progIll, progPriv, progTrap;

  always_comb begin
    progFpEn = instValid & (msrFe0 | msrFe1) & fpSummary;
    progIll  = instValid & isIllegal;
    progPriv = instValid & msrPr & (isPriv | (isSprMove & ~sprKnown & sprFieldMsb));
    progTrap = instValid & trapHit;
  end

  always_comb begin
    req           = '0;
    req[SRC_ITLB] = itlbMiss;
    req[SRC_PROG] = progFpEn | progIll | progPriv | progTrap;
    req[SRC_FPU]  = instValid & isFpOp & ~msrFp;
    req[SRC_SC]   = instValid & isSysCall;
    req[SRC_DLD]  = instValid & dtlbLoadMiss;
    req[SRC_DST]  = instValid & (dtlbStoreMiss | storeChangeNeeded);
    req[SRC_TRC]  = instValid & (msrSe | (isBranch & msrBe));
    req[SRC_CRIT] = critIn & msrCe;
    req[SRC_DEC]  = strobes.decReq & msrEe;
  end

  // Fixed-priority chain: a source wins if nothing above it requests
  assign seenAbove[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : gPrio
    assign grant[i]       = req[i] & ~seenAbove[i];
    assign seenAbove[i+1] = seenAbove[i] | req[i];
  end

  assign excValid = seenAbove[NUM_SRC];

  always_comb begin
    excVector = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) excVector = excVector | vecOf(i);
    end
  end

  // Program subtype, illegal > privileged > trap > fp enabled
  always_comb begin
    progCause = '0;
    if (grant[SRC_PROG]) begin
      if (progIll)       progCause[CAUSE_ILL]  = 1'b1;
      else if (progPriv) progCause[CAUSE_PRIV] = 1'b1;
      else if (progTrap) progCause[CAUSE_TRAP] = 1'b1;
      else               progCause[CAUSE_FPEN] = 1'b1;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R12

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !((excVector >= 20'h00B00 && excVector <= 20'h00BFF) ||
                   (excVector >= 20'h00E00 && excVector <= 20'h00FFF))); // R2

  AST_CAUSE_ONLY_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (progCause != '0) |-> (excValid && excVector == 20'h00700 && $onehot(progCause))); // R5

  AST_DEC_NEEDS_EE: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excVector == 20'h00900) |-> msrEe); // R7

  AST_CRIT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excVector == 20'h00A00) |-> (critIn && msrCe)); // R9

  AST_FPU_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excVector == 20'h00800) |-> (!msrFp && instValid)); // R6
endmodule

// File: rtl/excVectorUnit.sv
module excVectorUnit
  import excPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic        isIllegal,
  input  logic        isPriv,
  input  logic        trapHit,
  input  logic        isFpOp,
  input  logic        isSysCall,
  input  logic        isBranch,
  input  logic        isSprMove,
  input  logic        sprKnown,
  input  logic        sprFieldMsb,
  input  logic        fpSummary,
  input  logic        decTop,
  input  logic        critIn,
  input  logic        itlbMiss,
  input  logic        dtlbLoadMiss,
  input  logic        dtlbStoreMiss,
  input  logic        storeChangeNeeded,
  input  logic        msrFe0,
  input  logic        msrFe1,
  input  logic        msrPr,
  input  logic        msrFp,
  input  logic        msrEe,
  input  logic        msrCe,
  input  logic        msrSe,
  input  logic        msrBe,
  output logic        excValid,
  output logic [19:0] excVector,
  output logic [3:0]  progCause
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] grant;

  excCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .decTop   (decTop),
    .decTaken (grant[SRC_DEC]),
    .msrEe    (msrEe),
    .strobes  (strobes)
  );

  excDatapath dp_i (
    .clk               (clk),
    .rstN              (rstN),
    .strobes           (strobes),
    .instValid         (instValid),
    .isIllegal         (isIllegal),
    .isPriv            (isPriv),
    .trapHit           (trapHit),
    .isFpOp            (isFpOp),
    .isSysCall         (isSysCall),
    .isBranch          (isBranch),
    .isSprMove         (isSprMove),
    .sprKnown          (sprKnown),
    .sprFieldMsb       (sprFieldMsb),
    .fpSummary         (fpSummary),
    .critIn            (critIn),
    .itlbMiss          (itlbMiss),
    .dtlbLoadMiss      (dtlbLoadMiss),
    .dtlbStoreMiss     (dtlbStoreMiss),
    .storeChangeNeeded (storeChangeNeeded),
    .msrFe0            (msrFe0),
    .msrFe1            (msrFe1),
    .msrPr             (msrPr),
    .msrFp             (msrFp),
    .msrEe             (msrEe),
    .msrCe             (msrCe),
    .msrSe             (msrSe),
    .msrBe             (msrBe),
    .grant             (grant),
    .excValid          (excValid),
    .excVector         (excVector),
    .progCause         (progCause)
  );
endmodule

// File: tb/excVectorUnit_tb_top.sv
module excVectorUnit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  typedef struct packed {
    logic instValid, isIllegal, isPriv, trapHit, isFpOp, isSysCall, isBranch;
    logic isSprMove, sprKnown, sprFieldMsb, fpSummary, decTop, critIn;
    logic itlbMiss, dtlbLoadMiss, dtlbStoreMiss, storeChangeNeeded;
    logic msrFe0, msrFe1, msrPr, msrFp, msrEe, msrCe, msrSe, msrBe;
  } stim_t;

  typedef struct {
    logic        ev;
    logic [19:0] vec;
    logic [3:0]  cause;
    string       tag;
  } exp_t;

  stim_t s;
  exp_t  expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  logic        excValid;
  logic [19:0] excVector;
  logic [3:0]  progCause;

  excVectorUnit dut_i (
    .clk(clk), .rstN(rstN),
    .instValid(s.instValid), .isIllegal(s.isIllegal), .isPriv(s.isPriv),
    .trapHit(s.trapHit), .isFpOp(s.isFpOp), .isSysCall(s.isSysCall),
    .isBranch(s.isBranch), .isSprMove(s.isSprMove), .sprKnown(s.sprKnown),
    .sprFieldMsb(s.sprFieldMsb), .fpSummary(s.fpSummary), .decTop(s.decTop),
    .critIn(s.critIn), .itlbMiss(s.itlbMiss), .dtlbLoadMiss(s.dtlbLoadMiss),
    .dtlbStoreMiss(s.dtlbStoreMiss), .storeChangeNeeded(s.storeChangeNeeded),
    .msrFe0(s.msrFe0), .msrFe1(s.msrFe1), .msrPr(s.msrPr), .msrFp(s.msrFp),
    .msrEe(s.msrEe), .msrCe(s.msrCe), .msrSe(s.msrSe), .msrBe(s.msrBe),
    .excValid(excValid), .excVector(excVector), .progCause(progCause)
  );

  function automatic stim_t base();
    stim_t b = '0;
    b.msrFp = 1'b1;
    return b;
  endfunction

  // Driver: apply one cycle of stimulus and queue its expected result
  task automatic drive(input stim_t st, input logic ev, input logic [19:0] vec,
                       input logic [3:0] cause, input string tag);
    exp_t e;
    @(negedge clk);
    s = st;
    e.ev = ev; e.vec = vec; e.cause = cause; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare one cycle after inputs settle, before the next edge
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (excValid !== e.ev || excVector !== e.vec || progCause !== e.cause) begin
        errors++;
        $display("FAIL %s: got valid=%0b vec=%05h cause=%04b exp valid=%0b vec=%05h cause=%04b",
                 e.tag, excValid, excVector, progCause, e.ev, e.vec, e.cause);
      end
      checks++;
      if (excValid && ((excVector >= 20'h00B00 && excVector <= 20'h00BFF) ||
                       (excVector >= 20'h00E00 && excVector <= 20'h00FFF))) begin
        errors++;
        $display("FAIL R2: got reserved vec=%05h exp non-reserved", excVector);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t t;
    exp_t  e;
    // Reset with decrementer bit already high and enable set
    s = base();
    s.decTop = 1'b1;
    s.msrEe = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    e.ev = 1'b0; e.vec = '0; e.cause = '0; e.tag = "R7 level high at reset release";
    expQ.push_back(e);
    t = base(); t.decTop = 1; t.msrEe = 1;
    drive(t, 0, 20'h0, 4'b0, "R7 held level after reset");

    // R1 idle
    drive(base(), 0, 20'h0, 4'b0, "R1 idle");

    // R5 illegal and trap
    t = base(); t.instValid = 1; t.isIllegal = 1;
    drive(t, 1, 20'h00700, 4'b0010, "R5 illegal");
    t = base(); t.instValid = 1; t.trapHit = 1;
    drive(t, 1, 20'h00700, 4'b1000, "R5 trap");

    // R3 fp enabled
    t = base(); t.instValid = 1; t.fpSummary = 1; t.msrFe0 = 1;
    drive(t, 1, 20'h00700, 4'b0001, "R3 fe0");
    t = base(); t.instValid = 1; t.fpSummary = 1; t.msrFe1 = 1;
    drive(t, 1, 20'h00700, 4'b0001, "R3 fe1");
    t = base(); t.instValid = 1; t.fpSummary = 1;
    drive(t, 0, 20'h0, 4'b0, "R3 modes off");

    // R4 privileged
    t = base(); t.instValid = 1; t.isPriv = 1; t.msrPr = 1;
    drive(t, 1, 20'h00700, 4'b0100, "R4 priv user");
    t = base(); t.instValid = 1; t.isPriv = 1;
    drive(t, 0, 20'h0, 4'b0, "R4 priv supervisor");
    t = base(); t.instValid = 1; t.isSprMove = 1; t.sprFieldMsb = 1; t.msrPr = 1;
    drive(t, 1, 20'h00700, 4'b0100, "R4 spr msb set");
    t = base(); t.instValid = 1; t.isSprMove = 1; t.msrPr = 1;
    drive(t, 0, 20'h0, 4'b0, "R4 spr msb clear");
    t = base(); t.instValid = 1; t.isSprMove = 1; t.sprFieldMsb = 1; t.sprKnown = 1; t.msrPr = 1;
    drive(t, 0, 20'h0, 4'b0, "R4 spr known");

    // R5 subtype order
    t = base(); t.instValid = 1; t.isIllegal = 1; t.isPriv = 1; t.msrPr = 1; t.trapHit = 1;
    drive(t, 1, 20'h00700, 4'b0010, "R5 illegal over priv");
    t = base(); t.instValid = 1; t.isPriv = 1; t.msrPr = 1; t.trapHit = 1;
    drive(t, 1, 20'h00700, 4'b0100, "R5 priv over trap");
    t = base(); t.instValid = 1; t.trapHit = 1; t.fpSummary = 1; t.msrFe0 = 1;
    drive(t, 1, 20'h00700, 4'b1000, "R5 trap over fp enabled");

    // R6 fp unavailable
    t = base(); t.instValid = 1; t.isFpOp = 1; t.msrFp = 0;
    drive(t, 1, 20'h00800, 4'b0, "R6 fp off");
    t = base(); t.instValid = 1; t.isFpOp = 1;
    drive(t, 0, 20'h0, 4'b0, "R6 fp on");

    // R11 syscall and translation misses
    t = base(); t.instValid = 1; t.isSysCall = 1;
    drive(t, 1, 20'h00C00, 4'b0, "R11 syscall");
    t = base(); t.itlbMiss = 1;
    drive(t, 1, 20'h01000, 4'b0, "R11 itlb");
    t = base(); t.instValid = 1; t.dtlbLoadMiss = 1;
    drive(t, 1, 20'h01100, 4'b0, "R11 dload");
    t = base(); t.instValid = 1; t.dtlbStoreMiss = 1;
    drive(t, 1, 20'h01200, 4'b0, "R11 dstore");
    t = base(); t.instValid = 1; t.storeChangeNeeded = 1;
    drive(t, 1, 20'h01200, 4'b0, "R11 change bit");

    // R10 trace
    t = base(); t.instValid = 1; t.msrSe = 1;
    drive(t, 1, 20'h00D00, 4'b0, "R10 single step");
    t = base(); t.instValid = 1; t.isBranch = 1; t.msrBe = 1;
    drive(t, 1, 20'h00D00, 4'b0, "R10 branch step");
    t = base(); t.instValid = 1; t.isBranch = 1;
    drive(t, 0, 20'h0, 4'b0, "R10 branch no enable");
    t = base(); t.instValid = 1; t.msrBe = 1;
    drive(t, 0, 20'h0, 4'b0, "R10 enable no branch");

    // R9 critical
    t = base(); t.critIn = 1; t.msrCe = 1;
    drive(t, 1, 20'h00A00, 4'b0, "R9 crit enabled");
    t = base(); t.critIn = 1;
    drive(t, 0, 20'h0, 4'b0, "R9 crit disabled");

    // R12 priority pairs
    t = base(); t.instValid = 1; t.itlbMiss = 1; t.isIllegal = 1;
    drive(t, 1, 20'h01000, 4'b0, "R12 itlb over program");
    t = base(); t.instValid = 1; t.isIllegal = 1; t.isFpOp = 1; t.msrFp = 0;
    drive(t, 1, 20'h00700, 4'b0010, "R12 program over fpu");
    t = base(); t.instValid = 1; t.isFpOp = 1; t.msrFp = 0; t.isSysCall = 1;
    drive(t, 1, 20'h00800, 4'b0, "R12 fpu over syscall");
    t = base(); t.instValid = 1; t.isSysCall = 1; t.dtlbLoadMiss = 1;
    drive(t, 1, 20'h00C00, 4'b0, "R12 syscall over dload");
    t = base(); t.instValid = 1; t.dtlbLoadMiss = 1; t.dtlbStoreMiss = 1;
    drive(t, 1, 20'h01100, 4'b0, "R12 dload over dstore");
    t = base(); t.instValid = 1; t.dtlbStoreMiss = 1; t.msrSe = 1;
    drive(t, 1, 20'h01200, 4'b0, "R12 dstore over trace");
    t = base(); t.instValid = 1; t.msrSe = 1; t.critIn = 1; t.msrCe = 1;
    drive(t, 1, 20'h00D00, 4'b0, "R12 trace over crit");
    t = base(); t.critIn = 1; t.msrCe = 1; t.decTop = 1; t.msrEe = 1;
    drive(t, 1, 20'h00A00, 4'b0, "R12 crit over dec");
    t = base(); t.msrEe = 1;
    drive(t, 1, 20'h00900, 4'b0, "R8 masked rise kept pending");
    t = base(); t.msrEe = 1;
    drive(t, 0, 20'h0, 4'b0, "R8 pending cleared after take");

    // R13 instruction conditions need instValid
    t = base(); t.isIllegal = 1; t.isSysCall = 1; t.isFpOp = 1; t.msrFp = 0;
    t.msrSe = 1; t.dtlbLoadMiss = 1; t.storeChangeNeeded = 1;
    drive(t, 0, 20'h0, 4'b0, "R13 no instruction");
    t = base(); t.itlbMiss = 1; t.isIllegal = 1;
    drive(t, 1, 20'h01000, 4'b0, "R13 itlb without instruction");
    t = base(); t.critIn = 1; t.msrCe = 1; t.msrSe = 1;
    drive(t, 1, 20'h00A00, 4'b0, "R13 crit without instruction");

    // R7 edge behaviour
    t = base(); t.msrEe = 1;
    drive(t, 0, 20'h0, 4'b0, "R7 low");
    t.decTop = 1;
    drive(t, 1, 20'h00900, 4'b0, "R7 rise");
    drive(t, 0, 20'h0, 4'b0, "R7 held high no retrigger");
    drive(t, 0, 20'h0, 4'b0, "R7 held high again");

    // R8 rise while disabled
    t = base();
    drive(t, 0, 20'h0, 4'b0, "R8 low");
    t.decTop = 1;
    drive(t, 0, 20'h0, 4'b0, "R8 rise disabled");
    drive(t, 0, 20'h0, 4'b0, "R8 still disabled");
    t.msrEe = 1;
    drive(t, 1, 20'h00900, 4'b0, "R8 taken on enable");
    drive(t, 0, 20'h0, 4'b0, "R8 not taken twice");

    drive(base(), 0, 20'h0, 4'b0, "R1 idle end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule